// File: doc/BRIEF.md
# Dual-Clock FIFO With Programmable Threshold Flags

This block is a first-in first-out buffer between two clock domains. A producer writes one word per write-clock edge while its active-low write strobe is low, and a consumer pulls one word per read-clock edge into a registered data output while its active-low read strobe is low. The two clocks may be unrelated or the same net. Storage depth is a parameter (a power of two, 256 to 4096 words), and the word width defaults to 18 bits.

Five active-low status outputs report the fill state. Full and almost-full are produced in the write domain. Empty and almost-empty are produced in the read domain. Half-full is produced in the write domain. The almost-full margin `m` and the almost-empty margin `n` come either from two offset input buses or, when a select input is high, from built-in defaults that depend on the depth. A global active-low hold input suspends every data transfer on both ports. Pointers cross between domains as Gray code through two-stage synchronisers. A flag may therefore release a few cycles of the opposite clock late, but it never asserts late.

Top module: `dcf_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, that domain's pointer returns to zero. After reset, `full_n`, `afull_n` and `half_n` read 1, `empty_n` and `aempty_n` read 0, and `rd_data` reads 0.
- R2: A word is stored on a rising `wr_clk` edge when `wr_en_n`=0, `hold_n`=1 and `full_n`=1. A write attempted while `full_n`=0 is dropped and leaves the contents unchanged.
- R3: `rd_data` changes only on a rising `rd_clk` edge where `rd_en_n`=0, `hold_n`=1 and `empty_n`=1. Otherwise it holds its value. The first word after an empty state also needs such a read.
- R4: Words leave the buffer in the order they were accepted, with no loss and no duplication.
- R5: After DEPTH accepted writes with no reads, `full_n` goes 0 on the edge of the last write. `empty_n` goes 0 on the read edge that takes the last word. After a write into an empty buffer, `empty_n` rises within four `rd_clk` edges.
- R6: `afull_n` is 0 exactly when the write-side count plus `m` is at least DEPTH. The flag is updated on `wr_clk`.
- R7: `aempty_n` is 0 exactly when the read-side count is at most `n`. The flag is updated on `rd_clk`.
- R8: `half_n` goes 0 on the write edge that makes the count exceed DEPTH/2. It returns to 1 once the write side sees a count of DEPTH/2 or less.
- R9: With `use_dflt`=1 both margins equal the default (31 for depth 256, 63 for depth 512, 127 for 1024 and above), and the offset buses have no effect.
- R10: With `hold_n`=0, writes and reads are both ignored: no word is stored and `rd_data` holds.
- R11: With unrelated clock frequencies and a producer that keeps pushing, the buffer never overflows or underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| hold_n | input | 1 | Low suspends all writes and reads |
| use_dflt | input | 1 | High selects the built-in default margins |
| full_ofs | input | 12 | Almost-full margin `m` |
| empty_ofs | input | 12 | Almost-empty margin `n` |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_data | input | 18 | Write word |
| rd_en_n | input | 1 | Active-low read strobe |
| rd_data | output | 18 | Registered read word |
| full_n | output | 1 | Low when full (write domain) |
| afull_n | output | 1 | Low when almost full (write domain) |
| half_n | output | 1 | Low when more than half full (write domain) |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |

## Verification
Several properties are checked on every edge of their own domain:
- the write pointer freezes while full, and the output register freezes while empty, while the strobe is high or while held;
- neither domain's count ever exceeds the depth;
- full implies almost-full and half-full, and empty implies almost-empty.

The exact edges at which the margin flags assert for a given offset, the choice of default margins, and the order of words under unrelated clock rates need known stimulus. Those are shown only by the bench scenarios, which fill and drain the buffer against a reference queue.

// File: rtl/dcf_pkg.sv
// Package: shared constants and helpers for the dual-clock FIFO.
// Assumes DEPTH is a power of two.
package dcf_pkg;
    localparam int unsigned DCF_OFS_W = 12;

    // Default almost-empty / almost-full margin as a function of depth.
    function automatic int unsigned dflt_margin(input int unsigned depth);
        if (depth <= 256)      return 31;
        else if (depth <= 512) return 63;
        else                   return 127;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
// Two-stage synchroniser for a Gray-coded pointer bus.
// Assumes the source changes at most one bit per source clock.
module dcf_sync #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture the foreign bus and pass it through a second flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
// Simple dual-port storage: one synchronous write port, one
// combinational read port. Assumes the read address is stable
// in the read domain and refers only to already-written words.
module dcf_ram #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-domain control: write pointer, Gray pointer export, and the
// full, almost-full and half-full flags. The flags are computed from
// the next pointer value and the synchronised read pointer, so they
// assert on the very edge of the write that causes them. Release
// waits for the read pointer to cross.
module dcf_wr_ctl #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned OFS_W = 12,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_n,
    input  logic             hold_n,
    input  logic [OFS_W-1:0] margin,
    input  logic [PW-1:0]    rgray_s,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wgray,
    output logic [PW-1:0]    level,
    output logic             full_n,
    output logic             afull_n,
    output logic             half_n
);
    logic [PW-1:0] wbin, wbin_nx, rbin_s, cnt_nx;

    // Convert the synchronised Gray read pointer back to binary.
    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    // Accept a write and form the next pointer and the next count.
    always_comb begin
        we      = !wr_en_n && hold_n && full_n;
        wbin_nx = wbin + PW'(we);
        cnt_nx  = wbin_nx - rbin_s;
        level   = wbin - rbin_s;
    end

    assign waddr = wbin[AW-1:0];

    // Advance the pointer and register the write-side flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin    <= '0;
            wgray   <= '0;
            full_n  <= 1'b1;
            afull_n <= 1'b1;
            half_n  <= 1'b1;
        end else begin
            wbin    <= wbin_nx;
            wgray   <= wbin_nx ^ (wbin_nx >> 1);
            full_n  <= !(32'(cnt_nx) >= DEPTH);
            afull_n <= !(32'(cnt_nx) + 32'(margin) >= DEPTH);
            half_n  <= !(32'(cnt_nx) > DEPTH / 2);
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-domain control: read pointer, output register, Gray pointer
// export, and the empty and almost-empty flags. Assumes the storage
// read port is combinational on the current read address.
module dcf_rd_ctl #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned OFS_W  = 12,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned PW     = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_n,
    input  logic              hold_n,
    input  logic [OFS_W-1:0]  margin,
    input  logic [PW-1:0]     wgray_s,
    input  logic [DATA_W-1:0] ram_q,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [PW-1:0]     level,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;
    logic          re;

    // Convert the synchronised Gray write pointer back to binary.
    always_comb begin
        wbin_s[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    // Accept a read and form the next pointer and the next count.
    always_comb begin
        re      = !rd_en_n && hold_n && empty_n;
        rbin_nx = rbin + PW'(re);
        cnt_nx  = wbin_s - rbin_nx;
        level   = wbin_s - rbin;
    end

    assign raddr = rbin[AW-1:0];

    // Advance the pointer, load the output word, register the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin     <= '0;
            rgray    <= '0;
            rd_data  <= '0;
            empty_n  <= 1'b0;
            aempty_n <= 1'b0;
        end else begin
            rbin     <= rbin_nx;
            rgray    <= rbin_nx ^ (rbin_nx >> 1);
            if (re) rd_data <= ram_q;
            empty_n  <= (cnt_nx != '0);
            aempty_n <= !(32'(cnt_nx) <= 32'(margin));
        end
    end
endmodule

// File: rtl/dcf_top.sv
// Dual-clock FIFO with full, empty, half-full and two programmable
// margin flags, all active low. Assumes DEPTH is a power of two and
// that rst_n is held low for several edges of both clocks.
module dcf_top #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned OFS_W  = dcf_pkg::DCF_OFS_W
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              hold_n,
    input  logic              use_dflt,
    input  logic [OFS_W-1:0]  full_ofs,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_n,
    output logic              afull_n,
    output logic              half_n,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;
    localparam logic [OFS_W-1:0] DFLT = OFS_W'(dcf_pkg::dflt_margin(DEPTH));

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, wr_level, rd_level;
    logic [AW-1:0]     waddr, raddr;
    logic              we;
    logic [DATA_W-1:0] ram_q;
    logic [OFS_W-1:0]  m_sel, n_sel;

    assign m_sel = use_dflt ? DFLT : full_ofs;
    assign n_sel = use_dflt ? DFLT : empty_ofs;

    dcf_wr_ctl #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .hold_n(hold_n),
        .margin(m_sel), .rgray_s(rgray_s), .we(we), .waddr(waddr),
        .wgray(wgray), .level(wr_level), .full_n(full_n),
        .afull_n(afull_n), .half_n(half_n)
    );

    dcf_sync #(.W(PW)) i_sync_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
    dcf_sync #(.W(PW)) i_sync_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));

    dcf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ram (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(ram_q)
    );

    dcf_rd_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OFS_W(OFS_W)) i_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .hold_n(hold_n),
        .margin(n_sel), .wgray_s(wgray_s), .ram_q(ram_q), .raddr(raddr),
        .rgray(rgray), .level(rd_level), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );
endmodule

// File: rtl/dcf_checker.sv
// Checker for dcf_top: per-cycle protocol and flag-consistency rules.
// Attached to every dcf_top instance by the bind at the end.
module dcf_checker #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned PW    = $clog2(DEPTH) + 1
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              hold_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              full_n,
    input logic              afull_n,
    input logic              half_n,
    input logic              empty_n,
    input logic              aempty_n,
    input logic [PW-1:0]     wgray,
    input logic [PW-1:0]     wr_level,
    input logic [PW-1:0]     rd_level
);
    assert_drop_when_full_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en_n) |=> $stable(wgray));

    assert_hold_idle_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_en_n |=> $stable(rd_data));

    assert_no_underflow_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_data));

    assert_hold_blocks_R10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !hold_n |=> $stable(rd_data));

    assert_hold_blocks_wr_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !hold_n |=> $stable(wgray));

    assert_full_orders_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> (!afull_n && !half_n));

    assert_empty_orders_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    assert_no_overflow_R11: assert property (@(posedge wr_clk) disable iff (!rst_n)
        32'(wr_level) <= DEPTH);

    assert_rd_level_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        32'(rd_level) <= DEPTH);
endmodule

bind dcf_top dcf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dcf_checker (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .hold_n(hold_n),
    .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .rd_data(rd_data),
    .full_n(full_n), .afull_n(afull_n), .half_n(half_n),
    .empty_n(empty_n), .aempty_n(aempty_n), .wgray(wgray),
    .wr_level(wr_level), .rd_level(rd_level)
);

// File: tb/test_dcf_top.sv
// Directed bench for dcf_top: one task per scenario, each self-checking.
module test_dcf_top;
    localparam int DW = 18;
    localparam int D  = 256;

    logic wr_clk = 0, rd_clk = 0;
    logic rst_n = 0, hold_n = 1, use_dflt = 0;
    logic [11:0] full_ofs = 12'd40, empty_ofs = 12'd20;
    logic wr_en_n = 1, rd_en_n = 1;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full_n, afull_n, half_n, empty_n, aempty_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DW-1:0] model_q[$];

    always #4 wr_clk = ~wr_clk;      // 125 MHz
    always #5.5 rd_clk = ~rd_clk;    // unrelated read clock

    dcf_top #(.DATA_W(DW), .DEPTH(D)) i_dcf_top (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .hold_n(hold_n),
        .use_dflt(use_dflt), .full_ofs(full_ofs), .empty_ofs(empty_ofs),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .full_n(full_n), .afull_n(afull_n),
        .half_n(half_n), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write attempt; returns whether it was accepted.
    task automatic do_write(input logic [DW-1:0] d, output bit ok);
        @(negedge wr_clk);
        ok = full_n && hold_n;
        wr_en_n = 0; wr_data = d;
        @(negedge wr_clk);
        wr_en_n = 1;
    endtask

    // One read attempt; returns whether it was accepted.
    task automatic do_read(output bit ok);
        @(negedge rd_clk);
        ok = empty_n && hold_n;
        rd_en_n = 0;
        @(negedge rd_clk);
        rd_en_n = 1;
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (6) @(negedge rd_clk);
        rst_n = 1;
        settle();
        check("R1 full_n", full_n, 1);
        check("R1 afull_n", afull_n, 1);
        check("R1 half_n", half_n, 1);
        check("R1 empty_n", empty_n, 0);
        check("R1 aempty_n", aempty_n, 0);
        check("R1 rd_data", rd_data, 0);
    endtask

    task automatic t_first_word();
        bit ok;
        do_write(18'h15A5A, ok);
        repeat (4) @(negedge rd_clk);
        check("R5 empty release", empty_n, 1);
        check("R3 no auto load", rd_data, 0);
        do_read(ok);
        check("R3 first read", rd_data, 18'h15A5A);
        check("R5 empty after last", empty_n, 0);
        settle();
    endtask

    task automatic t_hold();
        bit ok;
        hold_n = 0;
        do_write(18'h00777, ok);
        settle();
        check("R10 write blocked", empty_n, 0);
        hold_n = 1;
        do_write(18'h00888, ok);
        settle();
        hold_n = 0;
        do_read(ok);
        check("R10 read blocked", rd_data, 18'h15A5A);
        hold_n = 1;
        do_read(ok);
        check("R10 after release", rd_data, 18'h00888);
        settle();
    endtask

    // Fill to full with margin m, then drain with margin n.
    task automatic t_fill_drain(input int m, input int n, input string tag);
        bit ok;
        int bad = 0;
        logic [DW-1:0] last;
        for (int k = 1; k <= D; k++) begin
            do_write(DW'(k * 37 + 5), ok);
            if (k == D - m - 1) check({tag, " R6 afull before"}, afull_n, 1);
            if (k == D - m)     check({tag, " R6 afull at"}, afull_n, 0);
            if (k == D / 2)     check({tag, " R8 half before"}, half_n, 1);
            if (k == D / 2 + 1) check({tag, " R8 half at"}, half_n, 0);
            if (k == D - 1)     check({tag, " R5 full before"}, full_n, 1);
        end
        check({tag, " R5 full"}, full_n, 0);
        do_write(18'h3DEAD, ok);
        check({tag, " R2 dropped"}, ok, 0);
        settle();
        for (int j = 1; j <= D; j++) begin
            do_read(ok);
            if (rd_data != DW'(j * 37 + 5)) bad++;
            if (D - j == n + 1) check({tag, " R7 aempty before"}, aempty_n, 1);
            if (D - j == n)     check({tag, " R7 aempty at"}, aempty_n, 0);
        end
        check({tag, " R4 R2 drain order"}, bad, 0);
        check({tag, " R5 empty"}, empty_n, 0);
        last = rd_data;
        do_read(ok);
        check({tag, " R3 empty read ignored"}, rd_data, last);
        settle();
        check({tag, " R8 half release"}, half_n, 1);
        check({tag, " R6 afull release"}, afull_n, 1);
    endtask

    // Unrelated-rate producer and consumer against a reference queue.
    task automatic t_stream();
        int bad = 0, got = 0;
        fork
            begin
                int sent = 0;
                bit ok;
                while (sent < 700) begin
                    do_write(DW'(sent * 11 + 3), ok);
                    if (ok) begin model_q.push_back(DW'(sent * 11 + 3)); sent++; end
                end
            end
            begin
                bit ok;
                repeat (500) @(negedge rd_clk);
                while (got < 700) begin
                    do_read(ok);
                    if (ok) begin
                        if (model_q.size() == 0 || rd_data != model_q[0]) bad++;
                        if (model_q.size() != 0) void'(model_q.pop_front());
                        got++;
                    end
                    if (got > 350) repeat (3) @(negedge rd_clk);
                end
            end
        join
        check("R4 R11 stream order", bad, 0);
        settle();
        check("R11 empty at end", empty_n, 0);
    endtask

    initial begin
        t_reset();
        t_first_word();
        t_hold();
        t_fill_drain(40, 20, "prog");
        use_dflt = 1;
        full_ofs = 12'd5; empty_ofs = 12'd9;
        settle();
        t_fill_drain(31, 31, "R9 dflt");
        use_dflt = 0; full_ofs = 12'd40; empty_ofs = 12'd20;
        t_stream();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule